// File: doc/BRIEF.md
# Serial Pin Activity Scanner

This block searches a bank of unlabelled board pins for a UART link and for the bit rate it runs at. Every candidate pin passes through a two-stage synchronizer. An edge logger then compares each pin with the last level it reported. When a pin in the current watch set differs, the logger emits a record that carries the pin index and the new level. It also carries the transmit pin and the rate code that were in force when the change was seen.

A scan is started with a one-cycle pulse and runs in one of three modes. Passive mode only listens, on every pin, for a fixed window. Active-broadcast mode takes the pins one at a time as transmitter. It drives a line-feed character out of that pin and watches every other pin. Active-pair mode steps through every ordered transmit/receive pair and watches only the receive pin. Both active modes repeat the whole pin sweep at three bit rates, slowest first.

The report port uses a valid/ready handshake. When the consumer is full, the scan pauses instead of dropping records. A done flag goes high once the last combination has been tried.

Top module: `uart_pin_scanner`

## Requirements
- R1: After reset no pin is driven (`pin_oe` all zero), `pin_do` is 1, `rpt_valid` is 0 and `done` is 0.
- R2: A pin level change is seen through two sampling flops. If `pins_in` changes before clock edge k, `rpt_valid` is first high after edge k+1, and it is still low after edge k.
- R3: In passive mode (`mode` 0, and `mode` 3 behaves the same) every pin is watched for `PASSIVE_CYC` unstalled cycles. Each change yields one record with `rpt_pin` = the pin index and `rpt_level` = the new level. When several pins are pending, the lowest index is reported first. `rpt_tx` reads 8'hFF in this mode.
- R4: In active-broadcast mode (`mode` 1) the transmit pin steps from 0 to NPINS-1, with `pin_oe` one-hot on that pin. `pin_do` sends a start bit 0, then 0x0A least significant bit first, then a stop bit 1, each bit lasting the current divisor in cycles. After the frame the line is held at 1 for `LISTEN_CYC` cycles. All pins except the driven one are watched, and the driven pin is never reported.
- R5: In both active modes the divisors are used in the order `DIV_SLOW`, `DIV_MID`, `DIV_FAST`. `rpt_baud` reports them as codes 0, 1 and 2.
- R6: In active-pair mode (`mode` 2) the order runs rate, then transmit pin, then receive pin. The receive pin skips the transmit pin. Only the receive pin is watched, and each record carries `rpt_tx` = transmit pin and `rpt_pin` = receive pin.
- R7: While `rpt_valid` is high and `rpt_ready` is low, every record field is held, pin sampling after the first flop is paused, and the window counters and the transmit frame are frozen. No record is lost.
- R8: At the start of a scan, and at the start of each transmit step, the current pin levels become the reference. Levels already present at that moment are not reported.
- R9: `done` rises after the final combination, stays high until the next start, and no pin is driven while it is high. A start pulse during a running scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| mode | input | 2 | Scan mode: 0 passive, 1 broadcast, 2 pair, 3 passive |
| pins_in | input | NPINS | Candidate pin levels |
| pin_oe | output | NPINS | One-hot drive enable for the transmit pin |
| pin_do | output | 1 | Serial level driven on the enabled pin |
| rpt_valid | output | 1 | Record available |
| rpt_ready | input | 1 | Consumer accepts the record |
| rpt_pin | output | 8 | Index of the pin that changed |
| rpt_level | output | 1 | New level of that pin |
| rpt_tx | output | 8 | Transmit pin in force, 8'hFF in passive mode |
| rpt_baud | output | 2 | Rate code in force |
| done | output | 1 | Scan complete |

## Verification
On every cycle the assertions check these properties:
- At most one pin is ever driven, and the driven pin never appears in a record.
- Records and the transmit line stay frozen while the consumer is stalled.
- The rate code stays in range, and the block stays silent once done.

Only the bench scenarios can show the rest, because each needs a full scan:
- the two-flop latency and the lowest-index-first order;
- the reference snapshot taken at each step;
- the exact frame bits;
- the step and rate ordering;
- whether an echoed response wired from one pin to another is found.

// File: rtl/uart_pin_scanner.sv
`timescale 1ns/1ps
module uart_pin_scanner #(
  parameter int NPINS       = 32,
  parameter int PASSIVE_CYC = 500_000_000,
  parameter int LISTEN_CYC  = 12_500_000,
  parameter int DIV_SLOW    = 13021,
  parameter int DIV_MID     = 3255,
  parameter int DIV_FAST    = 1085
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] pin_oe,
  output logic             pin_do,
  output logic             rpt_valid,
  input  logic             rpt_ready,
  output logic [7:0]       rpt_pin,
  output logic             rpt_level,
  output logic [7:0]       rpt_tx,
  output logic [1:0]       rpt_baud,
  output logic             done
);
  localparam int WMAX = (PASSIVE_CYC > LISTEN_CYC) ? PASSIVE_CYC : LISTEN_CYC;
  localparam int DMAX = (DIV_SLOW > DIV_MID) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                             : ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int WW = $clog2(WMAX + 1);
  localparam int DW = $clog2(DMAX + 1);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [9:0] FRAME = {1'b1, 8'h0A, 1'b0};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t st;
  logic [NPINS-1:0] s1, s2, last, mask, diff;
  logic [1:0] md, baud;
  logic [7:0] txp, rxp;
  logic listen;
  logic [3:0] bitn;
  logic [DW-1:0] bcnt, div_cur;
  logic [WW-1:0] wcnt;
  logic [IW-1:0] idx;
  logic [7:0] nx_tx, nx_rx;
  logic [1:0] nx_baud;
  logic last_step;

  wire run     = (st == S_RUN);
  wire passive = !(md == 2'd1 || md == 2'd2);
  wire perpin  = (md == 2'd2);
  wire active  = run && !passive;
  wire [NPINS-1:0] tx_hot = NPINS'(1) << txp;
  wire [NPINS-1:0] rx_hot = NPINS'(1) << rxp;

  always_comb begin
    if (!run)        mask = '0;
    else if (passive) mask = '1;
    else if (perpin) mask = rx_hot;
    else             mask = ~tx_hot;
  end

  assign diff = (s2 ^ last) & mask;

  always_comb begin
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (diff[i]) idx = IW'(i);
  end

  assign rpt_valid = |diff;
  assign rpt_pin   = 8'(idx);
  assign rpt_level = s2[idx];
  assign rpt_tx    = active ? txp : 8'hFF;
  assign rpt_baud  = baud;
  assign pin_oe    = active ? tx_hot : '0;
  assign pin_do    = !active || listen || FRAME[bitn];
  assign done      = (st == S_FIN);

  wire stall = rpt_valid && !rpt_ready;
  wire go    = run && !stall;

  always_comb begin
    case (baud)
      2'd0:    div_cur = DW'(DIV_SLOW - 1);
      2'd1:    div_cur = DW'(DIV_MID - 1);
      default: div_cur = DW'(DIV_FAST - 1);
    endcase
  end

  wire wend = passive ? (wcnt == WW'(PASSIVE_CYC - 1)) : (wcnt == WW'(LISTEN_CYC - 1));
  wire bend = (bcnt == div_cur);

  always_comb begin
    int t, r, b;
    t = int'(txp);
    r = int'(rxp);
    b = int'(baud);
    if (perpin) begin
      r = r + 1;
      if (r == t) r = r + 1;
      if (r >= NPINS) begin
        t = t + 1;
        r = 0;
      end
      if (t >= NPINS) begin
        t = 0;
        r = 1;
        b = b + 1;
      end
    end else begin
      t = t + 1;
      if (t >= NPINS) begin
        t = 0;
        b = b + 1;
      end
    end
    last_step = (b > 2);
    nx_tx   = 8'(t);
    nx_rx   = 8'(r);
    nx_baud = 2'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= '0; baud <= '0; txp <= '0; rxp <= '0;
      listen <= 1'b0; bitn <= '0; bcnt <= '0; wcnt <= '0;
      s1 <= '0; s2 <= '0; last <= '0;
    end else begin
      // R2: two sampling flops; the second holds while a record is stalled (R7)
      s1 <= pins_in;
      if (!stall) s2 <= s1;
      if (rpt_valid && rpt_ready) last[idx] <= s2[idx];
      if (!run && start) begin
        st <= S_RUN; md <= mode; baud <= '0; txp <= '0;
        rxp <= (mode == 2'd2) ? 8'd1 : 8'd0;
        listen <= 1'b0; bitn <= '0; bcnt <= '0; wcnt <= '0;
        last <= s2;
      end else if (go) begin
        if (passive) begin
          if (wend) st <= S_FIN;
          else      wcnt <= wcnt + 1'b1;
        end else if (!listen) begin
          if (bend) begin
            bcnt <= '0;
            if (bitn == 4'd9) begin
              listen <= 1'b1;
              wcnt <= '0;
            end else bitn <= bitn + 1'b1;
          end else bcnt <= bcnt + 1'b1;
        end else if (wend) begin
          if (last_step) st <= S_FIN;
          else begin
            baud <= nx_baud; txp <= nx_tx; rxp <= nx_rx;
            listen <= 1'b0; bitn <= '0; bcnt <= '0; wcnt <= '0;
            last <= s2;
          end
        end else wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

module uart_pin_scanner_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_oe,
  input logic             pin_do,
  input logic             rpt_valid,
  input logic             rpt_ready,
  input logic [7:0]       rpt_pin,
  input logic             rpt_level,
  input logic [7:0]       rpt_tx,
  input logic [1:0]       rpt_baud,
  input logic             done
);
  a_r4_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_oe));

  a_r4_no_self_report: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> ((pin_oe >> rpt_pin) & NPINS'(1)) == '0);

  a_r3_pin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> rpt_pin < 8'(NPINS));

  a_r5_baud_code: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_baud != 2'd3);

  a_r7_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_pin) && $stable(rpt_level)
                               && $stable(rpt_tx) && $stable(rpt_baud));

  a_r7_freeze_line: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> $stable(pin_oe) && $stable(pin_do));

  a_r9_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rpt_valid && pin_oe == '0);
endmodule

bind uart_pin_scanner uart_pin_scanner_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_do(pin_do),
  .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_pin(rpt_pin),
  .rpt_level(rpt_level), .rpt_tx(rpt_tx), .rpt_baud(rpt_baud), .done(done)
);

// File: tb/uart_pin_scanner_bench.sv
`timescale 1ns/1ps
module uart_pin_scanner_bench;
  localparam int NP = 4;
  localparam int PC = 60;
  localparam int LC = 30;
  localparam int DS = 4, DM = 3, DF = 2;

  logic clk = 0, rst_n = 0, start = 0, rpt_ready = 1;
  logic [1:0] mode = 0;
  logic [NP-1:0] pins_in = '0, ext = '0;
  logic [NP-1:0] pin_oe;
  logic pin_do, rpt_valid, rpt_level, done;
  logic [7:0] rpt_pin, rpt_tx;
  logic [1:0] rpt_baud;

  int compared = 0, mismatched = 0, cyc = 0;
  int echo_hits = 0, fast_hits = 0, pair_hits = 0, self_hits = 0;
  bit cmp_on = 0;

  uart_pin_scanner #(.NPINS(NP), .PASSIVE_CYC(PC), .LISTEN_CYC(LC),
    .DIV_SLOW(DS), .DIV_MID(DM), .DIV_FAST(DF)) u_uart_pin_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pins_in(pins_in),
    .pin_oe(pin_oe), .pin_do(pin_do), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_pin(rpt_pin), .rpt_level(rpt_level), .rpt_tx(rpt_tx), .rpt_baud(rpt_baud),
    .done(done));

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // board: driven pin loops back, pin 3 echoes the line while pin 1 transmits
  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) pins_in[i] <= pin_oe[i] ? pin_do : ext[i];
    if (pin_oe[1]) pins_in[3] <= pin_do;
  end

  // reference model
  int m_st, m_md, m_baud, m_tx, m_rx, m_bit, m_bc, m_wc;
  bit m_listen;
  logic [NP-1:0] m_s1, m_s2, m_last;
  int DV [3] = '{DS, DM, DF};

  function automatic bit m_pas(); return !(m_md == 1 || m_md == 2); endfunction
  function automatic bit m_act(); return m_st == 1 && !m_pas(); endfunction
  function automatic logic [NP-1:0] m_mask();
    logic [NP-1:0] v = '0;
    if (m_st != 1) return '0;
    for (int i = 0; i < NP; i++)
      v[i] = m_pas() ? 1'b1 : (m_md == 2 ? (i == m_rx) : (i != m_tx));
    return v;
  endfunction
  function automatic int m_first(logic [NP-1:0] d);
    for (int i = 0; i < NP; i++) if (d[i]) return i;
    return 0;
  endfunction
  function automatic bit m_frame(int b);
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return bit'((8'h0A >> (b - 1)) & 1);
  endfunction

  always @(posedge clk) begin : mdl
    logic [NP-1:0] d;
    int id;
    bit v, stl;
    if (!rst_n) begin
      m_st = 0; m_md = 0; m_baud = 0; m_tx = 0; m_rx = 0; m_bit = 0; m_bc = 0; m_wc = 0;
      m_listen = 0; m_s1 = '0; m_s2 = '0; m_last = '0;
    end else begin
      d = (m_s2 ^ m_last) & m_mask();
      v = (d != '0);
      id = m_first(d);
      stl = v && !rpt_ready;
      if (v && rpt_ready) m_last[id] = m_s2[id];
      if (m_st != 1 && start) begin
        m_st = 1; m_md = mode; m_baud = 0; m_tx = 0; m_rx = (mode == 2) ? 1 : 0;
        m_listen = 0; m_bit = 0; m_bc = 0; m_wc = 0; m_last = m_s2;
      end else if (m_st == 1 && !stl) begin
        if (m_pas()) begin
          if (m_wc == PC - 1) m_st = 2; else m_wc++;
        end else if (!m_listen) begin
          if (m_bc == DV[m_baud] - 1) begin
            m_bc = 0;
            if (m_bit == 9) begin m_listen = 1; m_wc = 0; end else m_bit++;
          end else m_bc++;
        end else if (m_wc == LC - 1) begin
          if (m_md == 2) begin
            do begin
              m_rx++;
              if (m_rx >= NP) begin
                m_rx = 0; m_tx++;
                if (m_tx >= NP) begin m_tx = 0; m_baud++; end
              end
            end while (m_rx == m_tx);
          end else begin
            m_tx++;
            if (m_tx >= NP) begin m_tx = 0; m_baud++; end
          end
          if (m_baud > 2) m_st = 2;
          else begin m_listen = 0; m_bit = 0; m_bc = 0; m_wc = 0; m_last = m_s2; end
        end else m_wc++;
      end
      if (!stl) m_s2 = m_s1;
      m_s1 = pins_in;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin : cmp
    logic [NP-1:0] d;
    string rq;
    if (rst_n && cmp_on) begin
      d = (m_s2 ^ m_last) & m_mask();
      rq = (m_md == 2) ? "R6" : (m_pas() ? "R3" : "R4");
      chk("R4 pin_oe", int'(pin_oe), m_act() ? (1 << m_tx) : 0);
      chk("R4 pin_do", int'(pin_do), int'(!m_act() || m_listen || m_frame(m_bit)));
      chk("R9 done", int'(done), int'(m_st == 2));
      chk({rq, " rpt_valid"}, int'(rpt_valid), int'(d != '0));
      if (d != '0) begin
        chk({rq, " rpt_pin"}, int'(rpt_pin), m_first(d));
        chk({rq, " rpt_level"}, int'(rpt_level), int'(m_s2[m_first(d)]));
        chk("R6 rpt_tx", int'(rpt_tx), m_act() ? m_tx : 255);
        chk("R5 rpt_baud", int'(rpt_baud), m_baud);
      end
      if (rpt_valid && rpt_ready) begin
        if (rpt_tx == 8'd1 && rpt_pin == 8'd3 && m_md == 1) echo_hits++;
        if (rpt_baud == 2'd2 && rpt_tx != 8'hFF) fast_hits++;
        if (rpt_tx == 8'd1 && rpt_pin == 8'd3 && m_md == 2) pair_hits++;
        if (rpt_tx == rpt_pin) self_hits++;
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic kick(int md);
    mode = 2'(md); start = 1;
    step();
    start = 0;
  endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit && !done; i++) step();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    step(4);
    rst_n = 1;
    step();
    cmp_on = 1;
    // R1: quiet after reset
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 pin_do", int'(pin_do), 1);
    chk("R1 rpt_valid", int'(rpt_valid), 0);
    chk("R1 done", int'(done), 0);

    // R8: a level present before start is not reported
    ext = 4'b0010;
    step(4);
    kick(0);
    for (int i = 0; i < 5; i++) begin
      chk("R8 no stale report", int'(rpt_valid), 0);
      step();
    end

    // R9: start during a run is ignored
    kick(1);
    step();
    chk("R9 start ignored", int'(pin_oe), 0);

    // R2: two-flop latency
    ext[2] = 1;
    step();
    step();
    chk("R2 not yet", int'(rpt_valid), 0);
    step();
    chk("R2 seen", int'(rpt_valid), 1);
    chk("R2 pin", int'(rpt_pin), 2);
    chk("R2 level", int'(rpt_level), 1);
    step(2);

    // R3: simultaneous changes reported lowest index first
    ext[1] = 0; ext[3] = 1;
    step(3);
    chk("R3 first pin", int'(rpt_pin), 1);
    chk("R3 first level", int'(rpt_level), 0);
    step();
    chk("R3 second pin", int'(rpt_pin), 3);
    chk("R3 tx code", int'(rpt_tx), 255);
    step(2);

    // R7: backpressure holds the record
    rpt_ready = 0;
    ext[0] = 1;
    step(12);
    chk("R7 held valid", int'(rpt_valid), 1);
    chk("R7 held pin", int'(rpt_pin), 0);
    rpt_ready = 1;
    step();
    chk("R7 released", int'(rpt_valid), 0);

    wait_done(200);
    chk("R9 passive done", int'(done), 1);
    step(3);
    chk("R9 done held", int'(done), 1);

    // R4, R5: broadcast scan
    ext = '0;
    kick(1);
    wait_done(5000);
    chk("R9 broadcast done", int'(done), 1);
    chk("R4 echo found", int'(echo_hits > 0), 1);
    chk("R5 fast rate used", int'(fast_hits > 0), 1);

    // R6: pair scan
    kick(2);
    wait_done(10000);
    chk("R9 pair done", int'(done), 1);
    chk("R6 pair found", int'(pair_hits > 0), 1);
    chk("R6 no self pair", self_hits, 0);

    step(2);
    finish_run();
  end
endmodule